// File: doc/BRIEF.md
# Receive Entry Packer

The packer sits between a serial receiver and a 32-bit receive FIFO. Each accepted serial bit is written into a programmable bit position of an assembly word. Four 10-bit placement vectors decide where each bit lands. A vector gives a starting bit index, a walking direction and a run length, and it can carry an end flag. Bits are never shifted in. Each one is scattered to the position its vector names, so byte order, bit order and narrow words can be laid out in any arrangement inside the entry.

The entry is handed to the FIFO over a valid/ready pair once the vector marked as last has received all of its bits. A flush request sends out a partly filled entry early. When the FIFO side holds back a finished entry, the serial side is stalled through its own ready signal, and an overrun indication shows that a bit was offered and refused.

Top module: `rx_word_packer`

## Requirements
- R1: Each 10-bit vector is decoded as: start index in bits [9:5], direction in bit [4] (1 = walk down, 0 = walk up), run length minus one in bits [3:1], and end flag in bit [0]. Vector 0 sits in `cfg_lo[9:0]`, vector 1 in `cfg_lo[19:10]`, vector 2 in `cfg_hi[9:0]` and vector 3 in `cfg_hi[19:10]`.
- R2: A vector places (length-minus-one + 1) consecutive accepted bits. The first of these goes to its start index. Each following bit goes one position lower when direction is 1, or one position higher when direction is 0. Positions wrap modulo 32.
- R3: Vectors are used in order 0, 1, 2, 3. The entry is complete after the last bit of the first vector whose end flag is set. Vector 3 always ends the entry, even if its end flag is clear.
- R4: Any bit position that no vector wrote reads as 0 in the pushed entry.
- R5: While `ent_vld` is 1 and `ent_rdy` is 0, `ent_vld` stays 1 and `ent_data` does not change.
- R6: `bit_rdy` is 0 exactly when a held entry is not being taken (`ent_vld`=1, `ent_rdy`=0). A bit offered while `bit_rdy` is 0 is not consumed, and `overrun` is 1 in that cycle.
- R7: A flush taken while bits are pending pushes the partial entry and restarts placement at vector 0 with an empty assembly word.
- R8: A flush taken with no pending bits and no bit in the same cycle pushes nothing.
- R9: After reset, `ent_vld` is 0, `bit_rdy` is 1 and placement starts at vector 0.
- R10: An entry appears on `ent_vld` in the cycle after its final bit is accepted. A bit accepted in the same cycle as a flush is included in the flushed entry. A flush is only taken while `bit_rdy` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_lo | input | 20 | Placement vectors 0 (low) and 1 (high) |
| cfg_hi | input | 20 | Placement vectors 2 (low) and 3 (high) |
| bit_vld | input | 1 | Serial bit offered |
| bit_in | input | 1 | Serial bit value |
| bit_rdy | output | 1 | Packer can accept a bit or flush |
| flush | input | 1 | Push the partial entry now |
| ent_vld | output | 1 | Entry valid toward the FIFO |
| ent_data | output | 32 | Packed entry |
| ent_rdy | input | 1 | FIFO accepts the entry |
| overrun | output | 1 | Bit offered while stalled |

## Verification
The bench builds the packer with its default four-vector, 32-bit entry. With that setting every vector slot can be reached, so layouts that end at vector 0, vector 1 and vector 3 are all exercised, as well as the case where vector 3 ends the entry without its end flag. The table covers upward and downward walks, runs of 5, 7 and 8 bits, and gaps between runs that must read as zero. The directed part holds an entry under backpressure, issues flushes with and without pending bits, and folds a bit into a flush in the same cycle.

// File: rtl/rxpk_pkg.sv
package rxpk_pkg;
  localparam int ENTRY_W = 32;
  localparam int SLOT_W  = $clog2(ENTRY_W);
  localparam int RUN_W   = 3;
  localparam int VEC_W   = SLOT_W + 1 + RUN_W + 1;
  localparam int VEC_PER_REG = 2;
  localparam int CFG_W   = VEC_PER_REG * VEC_W;

  // Field order matters: a packed struct lists its fields from the msb down.
  typedef struct packed {
    logic [SLOT_W-1:0] start;
    logic              down;
    logic [RUN_W-1:0]  runm1;
    logic              last;
  } pvec_t;

  // Bit position reached after idx steps along a vector's walk.
  function automatic logic [SLOT_W-1:0] slot_of(pvec_t v, logic [RUN_W-1:0] idx);
    logic [SLOT_W-1:0] ofs;
    ofs = SLOT_W'(idx);
    return v.down ? (v.start - ofs) : (v.start + ofs);
  endfunction
endpackage

// File: rtl/rxpk_vec_sel.sv
module rxpk_vec_sel
  import rxpk_pkg::*;
#(
  parameter int NVEC = 4,
  localparam int VI_W = $clog2(NVEC)
) (
  input  logic [NVEC*VEC_W-1:0] cfg_all,
  input  logic [VI_W-1:0]       idx,
  output pvec_t                 cur
);
  pvec_t tbl [NVEC];

  for (genvar g = 0; g < NVEC; g++) begin : g_vec
    assign tbl[g] = pvec_t'(cfg_all[g*VEC_W +: VEC_W]);
  end

  assign cur = tbl[idx];
endmodule

// File: rtl/rxpk_cursor.sv
module rxpk_cursor
  import rxpk_pkg::*;
#(
  parameter int NVEC = 4,
  localparam int VI_W = $clog2(NVEC)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             take,
  input  logic             restart,
  input  pvec_t            cur,
  output logic [VI_W-1:0]  vi_q,
  output logic [RUN_W-1:0] bc_q,
  output logic             pend_q,
  output logic             run_end,
  output logic             ent_end
);
  logic last_slot_vec;

  assign last_slot_vec = (vi_q == VI_W'(NVEC-1));
  assign run_end       = take && (bc_q == cur.runm1);
  assign ent_end       = run_end && (cur.last || last_slot_vec);

  always_ff @(posedge clk) begin
    if (!rst_n || restart) begin
      vi_q   <= '0;
      bc_q   <= '0;
      pend_q <= 1'b0;
    end else if (take) begin
      pend_q <= 1'b1;
      if (run_end) begin
        vi_q <= vi_q + 1'b1;
        bc_q <= '0;
      end else begin
        bc_q <= bc_q + 1'b1;
      end
    end
  end

  AST_RUN_WITHIN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(cur) |-> bc_q <= cur.runm1) else $error("run count past length"); // R2
endmodule

// File: rtl/rxpk_out_stage.sv
module rxpk_out_stage
  import rxpk_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [ENTRY_W-1:0] din,
  input  logic               ent_rdy,
  output logic               ent_vld,
  output logic [ENTRY_W-1:0] ent_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_vld  <= 1'b0;
      ent_data <= '0;
    end else if (load) begin
      ent_vld  <= 1'b1;
      ent_data <= din;
    end else if (ent_rdy) begin
      ent_vld  <= 1'b0;
    end
  end

  AST_HOLD_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    ent_vld && !ent_rdy |=> ent_vld && $stable(ent_data)) else $error("held entry changed"); // R5
endmodule

// File: rtl/rx_word_packer.sv
module rx_word_packer
  import rxpk_pkg::*;
#(
  parameter int NVEC = 4,
  localparam int VI_W = $clog2(NVEC)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CFG_W-1:0]   cfg_lo,
  input  logic [CFG_W-1:0]   cfg_hi,
  input  logic               bit_vld,
  input  logic               bit_in,
  output logic               bit_rdy,
  input  logic               flush,
  output logic               ent_vld,
  output logic [ENTRY_W-1:0] ent_data,
  input  logic               ent_rdy,
  output logic               overrun
);
  pvec_t              cur;
  logic [VI_W-1:0]    vi_q;
  logic [RUN_W-1:0]   bc_q;
  logic               pend_q;
  logic               run_end;
  logic               ent_end;
  logic               take;
  logic               flush_push;
  logic               push;
  logic [SLOT_W-1:0]  slot;
  logic [ENTRY_W-1:0] acc_q;
  logic [ENTRY_W-1:0] acc_w;

  assign bit_rdy    = !ent_vld || ent_rdy;
  assign take       = bit_vld && bit_rdy;
  assign overrun    = bit_vld && !bit_rdy;
  assign flush_push = flush && bit_rdy && (pend_q || take);
  assign push       = ent_end || flush_push;
  assign slot       = slot_of(cur, bc_q);

  rxpk_vec_sel #(.NVEC(NVEC)) u_sel (
    .cfg_all ({cfg_hi, cfg_lo}),
    .idx     (vi_q),
    .cur     (cur)
  );

  rxpk_cursor #(.NVEC(NVEC)) u_cur (
    .clk     (clk),
    .rst_n   (rst_n),
    .take    (take),
    .restart (push),
    .cur     (cur),
    .vi_q    (vi_q),
    .bc_q    (bc_q),
    .pend_q  (pend_q),
    .run_end (run_end),
    .ent_end (ent_end)
  );

  always_comb begin
    acc_w = acc_q;
    if (take) acc_w[slot] = bit_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || push) acc_q <= '0;
    else                acc_q <= acc_w;
  end

  rxpk_out_stage u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (push),
    .din      (acc_w),
    .ent_rdy  (ent_rdy),
    .ent_vld  (ent_vld),
    .ent_data (ent_data)
  );

  AST_STALL_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    bit_vld && !bit_rdy |=> $stable(acc_q) && $stable(vi_q) && $stable(bc_q)) else $error("stalled bit consumed"); // R6
  AST_PUSH_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    push |=> vi_q == '0 && bc_q == '0 && !pend_q && acc_q == '0) else $error("no restart after push"); // R7
  AST_IDLE_FLUSH: assert property (@(posedge clk) disable iff (!rst_n)
    flush && !pend_q && !bit_vld && !ent_vld |=> !ent_vld) else $error("idle flush pushed"); // R8
  AST_END_PUSHES: assert property (@(posedge clk) disable iff (!rst_n)
    run_end && cur.last |=> ent_vld) else $error("end vector did not push"); // R3
endmodule

// File: tb/rx_word_packer_tb_top.sv
`timescale 1ns/1ps
module rx_word_packer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] cfg_lo = '0;
  logic [19:0] cfg_hi = '0;
  logic        bit_vld = 1'b0;
  logic        bit_in = 1'b0;
  logic        bit_rdy;
  logic        flush = 1'b0;
  logic        ent_vld;
  logic [31:0] ent_data;
  logic        ent_rdy = 1'b1;
  logic        overrun;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  rx_word_packer dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_lo(cfg_lo), .cfg_hi(cfg_hi),
    .bit_vld(bit_vld), .bit_in(bit_in), .bit_rdy(bit_rdy), .flush(flush),
    .ent_vld(ent_vld), .ent_data(ent_data), .ent_rdy(ent_rdy), .overrun(overrun)
  );

  // cfg_lo, cfg_hi, data bits (sent bit 0 first), expected entry
  localparam logic [19:0] T_LO  [6] = '{ {10'h10E,10'h00E}, {10'h1FE,10'h0FE}, {10'h10D,10'h00C},
                                         {10'h000,10'h159}, {10'h10E,10'h00E}, {10'h10C,10'h00E} };
  localparam logic [19:0] T_HI  [6] = '{ {10'h30F,10'h20E}, {10'h3FF,10'h2FE}, {10'h000,10'h000},
                                         {10'h000,10'h000}, {10'h30E,10'h20E}, {10'h30D,10'h20E} };
  localparam logic [31:0] T_DAT [6] = '{ 32'hA5C396F0, 32'h00000101, 32'h00003FFF,
                                         32'h00000013, 32'hFFFFFFFF, 32'h3FFFFFFF };
  localparam logic [31:0] T_EXP [6] = '{ 32'hA5C396F0, 32'h00008080, 32'h00007F7F,
                                         32'h00000640, 32'hFFFFFFFF, 32'h7FFF7FFF };

  // Bits an entry needs: run lengths summed up to the end-flagged vector or vector 3 (R1, R3).
  function automatic int bits_needed(logic [19:0] lo, logic [19:0] hi);
    logic [39:0] all;
    int total;
    all = {hi, lo};
    total = 0;
    for (int v = 0; v < 4; v++) begin
      total += int'(all[v*10+1 +: 3]) + 1;
      if (all[v*10]) return total;
    end
    return total;
  endfunction

  task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic finish_test();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_bad);
    $finish;
  endtask

  // Drives n bits; the last one may carry a flush. Returns at the negedge after the final bit's edge.
  task automatic send(logic [31:0] data, int n, bit flush_last);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bit_vld = 1'b1;
      bit_in  = data[i];
      flush   = flush_last && (i == n-1);
    end
    @(negedge clk);
    bit_vld = 1'b0;
    flush   = 1'b0;
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: actual %h expected %h", 32'h0, 32'h1);
      finish_test();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R9: reset state
    check(ent_vld == 1'b0, "R9", 32'(ent_vld), 32'h0);
    check(bit_rdy == 1'b1, "R9", 32'(bit_rdy), 32'h1);
    rst_n = 1'b1;
    @(negedge clk);

    // Table walk: R1 R2 R3 R4 R10
    for (int t = 0; t < 6; t++) begin
      cfg_lo = T_LO[t];
      cfg_hi = T_HI[t];
      send(T_DAT[t], bits_needed(T_LO[t], T_HI[t]) - 1, 1'b0);
      check(ent_vld == 1'b0, "R10", 32'(ent_vld), 32'h0);
      send(T_DAT[t] >> (bits_needed(T_LO[t], T_HI[t]) - 1), 1, 1'b0);
      check(ent_vld == 1'b1, "R10", 32'(ent_vld), 32'h1);
      check(ent_data == T_EXP[t], "R2 R4", ent_data, T_EXP[t]);
      @(negedge clk);
    end

    // R5 R6: backpressure with a stalled bit
    cfg_lo = T_LO[0];
    cfg_hi = T_HI[0];
    ent_rdy = 1'b0;
    send(32'h12345678, 32, 1'b0);
    bit_vld = 1'b1;
    bit_in  = 1'b1;
    #1;
    check(bit_rdy == 1'b0, "R6", 32'(bit_rdy), 32'h0);
    check(overrun == 1'b1, "R6", 32'(overrun), 32'h1);
    repeat (3) @(negedge clk);
    check(ent_vld == 1'b1 && ent_data == 32'h12345678, "R5", ent_data, 32'h12345678);
    bit_vld = 1'b0;
    ent_rdy = 1'b1;
    @(negedge clk);
    check(ent_vld == 1'b0, "R5", 32'(ent_vld), 32'h0);
    // the stalled bit must not have entered the next entry
    send(32'h0F0F0F0E, 32, 1'b0);
    check(ent_data == 32'h0F0F0F0E, "R6", ent_data, 32'h0F0F0F0E);
    @(negedge clk);

    // R7: flush of a partial entry, then a clean restart
    send(32'h000002AB, 10, 1'b0);
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(ent_vld == 1'b1 && ent_data == 32'h000002AB, "R7", ent_data, 32'h000002AB);
    @(negedge clk);
    send(32'hCAFEF00D, 32, 1'b0);
    check(ent_data == 32'hCAFEF00D, "R7", ent_data, 32'hCAFEF00D);
    @(negedge clk);

    // R8: flush with nothing pending
    flush = 1'b1;
    @(negedge clk);
    flush = 1'b0;
    check(ent_vld == 1'b0, "R8", 32'(ent_vld), 32'h0);
    @(negedge clk);
    check(ent_vld == 1'b0, "R8", 32'(ent_vld), 32'h0);

    // R10: a bit taken alongside a flush is included
    send(32'h00000005, 3, 1'b1);
    check(ent_vld == 1'b1 && ent_data == 32'h00000005, "R10", ent_data, 32'h5);
    @(negedge clk);

    done = 1'b1;
    finish_test();
  end
endmodule